// File: doc/BRIEF.md
# Atomic Synchronisation Register File

This block holds a small set of shared 64-bit words. Several processors use it to coordinate parallel work. Each requester port issues one command. A command is either an indivisible read-modify-write on one word or a request to interrupt other processors. The response returns the word's previous contents, so a processor can build locks, barriers and work counters without a bus lock.

There are two banks. The user bank is open to every request. The supervisor bank accepts only requests that carry the privilege bit. Requests from all ports compete for a single operation slot each cycle. A round-robin arbiter picks the winner, so two operations never overlap on any word. Interrupt commands travel through the same ports. They produce one-cycle pulses on per-CPU interrupt lines.

Top module: `acrf_sync_regfile`

## Requirements
- R1: After reset every word in both banks reads 0, and `rsp_valid`, `rsp_err`, `irq_out` and `req_ready` are all 0 while no request is pending.
- R2: At most one port is granted per cycle, and only a port with `req_valid` high. When several ports request, grants rotate round-robin, so four ports that request together are served in four consecutive cycles.
- R3: The cycle after a grant, the granted port sees `rsp_valid` high for exactly one cycle. `rsp_data` then holds the word's contents from before the operation.
- R4: Opcode 1 (test-and-set) returns the old word and stores it with bit 63 forced to 1.
- R5: Opcode 2 (AND) and opcode 3 (OR) store the old word combined bitwise with the operand.
- R6: Opcode 4 (fetch-increment) stores old+1. Opcode 5 (add) stores old+operand. Both wrap modulo 2^64.
- R7: Opcode 0 (load) returns the word and leaves it unchanged.
- R8: `req_bank`=1 selects the supervisor bank. A request to it with `req_priv`=0 returns `rsp_err`=1 and `rsp_data`=0, and leaves the word unchanged. User-bank and supervisor-bank words at the same index are independent.
- R9: Opcode 6 (single interrupt) pulses `irq_out[operand]` for one cycle, in the response cycle. An operand of `NUM_CPUS` or above pulses no line. No word changes and `rsp_data` is 0.
- R10: Opcode 7 (mask interrupt) pulses, for one cycle, every `irq_out` line whose bit is set in the operand's low `NUM_CPUS` bits. Higher operand bits are ignored.
- R11: Concurrent fetch-increments from all ports to one word return distinct old values. The final count equals the number of requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_PORTS | Request pending, one bit per port |
| req_ready | output | NUM_PORTS | Grant this cycle, one bit per port |
| req_op | input | 3*NUM_PORTS | Opcode per port |
| req_bank | input | NUM_PORTS | Bank select (1 = supervisor) |
| req_priv | input | NUM_PORTS | Requester privilege |
| req_idx | input | IDX_W*NUM_PORTS | Word index per port |
| req_operand | input | DATA_W*NUM_PORTS | Operand per port |
| rsp_valid | output | NUM_PORTS | Response strobe per port |
| rsp_err | output | NUM_PORTS | Refused privileged access |
| rsp_data | output | DATA_W*NUM_PORTS | Previous word contents per port |
| irq_out | output | NUM_CPUS | Interrupt pulse per CPU |

## Verification
Most internal faults show up at the ports within one or two cycles. A corrupted stored word appears in the next response from that word, because every operation returns the old value. A lost or doubled update breaks the concurrent fetch-increment sequence. That shows up as a repeated return value or a wrong final count. An arbiter fault shows up at once as two grants or a starved port. A fault in the interrupt path shows up as a wrong or lingering line in the response cycle.

// File: rtl/acrf_pkg.sv
`timescale 1ns/1ps
package acrf_pkg;
   typedef enum logic [2:0] {
      OP_LOAD     = 3'd0,
      OP_TAS      = 3'd1,
      OP_AND      = 3'd2,
      OP_OR       = 3'd3,
      OP_FINC     = 3'd4,
      OP_ADD      = 3'd5,
      OP_IRQ_ONE  = 3'd6,
      OP_IRQ_MASK = 3'd7
   } acrf_op_e;
endpackage

// File: rtl/acrf_rr_arbiter.sv
`timescale 1ns/1ps
module acrf_rr_arbiter #(
   parameter int N    = 4,
   parameter int IW   = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] gnt_idx
);
   logic [IW-1:0] ptr;
   logic          found;

   always_comb begin
      gnt     = '0;
      gnt_idx = '0;
      found   = 1'b0;
      for (int k = 0; k < N; k++) begin
         int cand;
         cand = (int'(ptr) + k) % N;
         if (!found && req[cand]) begin
            found     = 1'b1;
            gnt[cand] = 1'b1;
            gnt_idx   = IW'(cand);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      ptr <= '0;
      else if (found)  ptr <= IW'((int'(gnt_idx) + 1) % N);
   end
endmodule

// File: rtl/acrf_atomic_alu.sv
`timescale 1ns/1ps
module acrf_atomic_alu
   import acrf_pkg::*;
#(
   parameter int W = 64
) (
   input  acrf_op_e     op,
   input  logic [W-1:0] old_val,
   input  logic [W-1:0] operand,
   output logic [W-1:0] new_val,
   output logic         do_write
);
   always_comb begin
      new_val  = old_val;
      do_write = 1'b1;
      unique case (op)
         OP_TAS:  new_val = {1'b1, old_val[W-2:0]};
         OP_AND:  new_val = old_val & operand;
         OP_OR:   new_val = old_val | operand;
         OP_FINC: new_val = old_val + W'(1);
         OP_ADD:  new_val = old_val + operand;
         default: do_write = 1'b0;
      endcase
   end
endmodule

// File: rtl/acrf_irq_fanout.sv
`timescale 1ns/1ps
module acrf_irq_fanout
   import acrf_pkg::*;
#(
   parameter int NCPU = 8,
   parameter int W    = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fire,
   input  acrf_op_e        op,
   input  logic [W-1:0]    operand,
   output logic [NCPU-1:0] irq
);
   logic [NCPU-1:0] nxt;

   always_comb begin
      nxt = '0;
      if (fire && op == OP_IRQ_MASK) nxt = operand[NCPU-1:0];
      if (fire && op == OP_IRQ_ONE) begin
         for (int c = 0; c < NCPU; c++)
            if (operand == W'(c)) nxt[c] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) irq <= '0;
      else        irq <= nxt;
   end
endmodule

// File: rtl/acrf_sync_regfile.sv
`timescale 1ns/1ps
module acrf_sync_regfile
   import acrf_pkg::*;
#(
   parameter int NUM_PORTS = 4,
   parameter int NUM_REGS  = 128,
   parameter int DATA_W    = 64,
   parameter int NUM_CPUS  = 8
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [NUM_PORTS-1:0]                 req_valid,
   output logic [NUM_PORTS-1:0]                 req_ready,
   input  logic [NUM_PORTS*3-1:0]               req_op,
   input  logic [NUM_PORTS-1:0]                 req_bank,
   input  logic [NUM_PORTS-1:0]                 req_priv,
   input  logic [NUM_PORTS*$clog2(NUM_REGS)-1:0] req_idx,
   input  logic [NUM_PORTS*DATA_W-1:0]          req_operand,
   output logic [NUM_PORTS-1:0]                 rsp_valid,
   output logic [NUM_PORTS-1:0]                 rsp_err,
   output logic [NUM_PORTS*DATA_W-1:0]          rsp_data,
   output logic [NUM_CPUS-1:0]                  irq_out
);
   localparam int IDX_W   = $clog2(NUM_REGS);
   localparam int PI_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
   localparam int DEPTH   = 2 * NUM_REGS;
   localparam int ADDR_W  = IDX_W + 1;

   if (NUM_CPUS > DATA_W) begin : g_bad_cpus
      $error("NUM_CPUS must not exceed DATA_W");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end
   if (NUM_PORTS < 1 || NUM_REGS < 2) begin : g_bad_count
      $error("NUM_PORTS >= 1 and NUM_REGS >= 2 required");
   end

   logic [PI_W-1:0]   gidx;
   logic              any_gnt;
   acrf_op_e          sel_op;
   logic              sel_bank, sel_priv;
   logic [IDX_W-1:0]  sel_idx;
   logic [DATA_W-1:0] sel_operand;
   logic [ADDR_W-1:0] sel_addr;
   logic [DATA_W-1:0] old_val, new_val;
   logic              alu_wr, refused, is_irq, commit;
   logic [DATA_W-1:0] words [DEPTH];

   acrf_rr_arbiter #(.N(NUM_PORTS), .IW(PI_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(req_valid), .gnt(req_ready), .gnt_idx(gidx)
   );

   always_comb begin
      any_gnt     = |req_ready;
      sel_op      = acrf_op_e'(req_op[int'(gidx)*3 +: 3]);
      sel_bank    = req_bank[gidx];
      sel_priv    = req_priv[gidx];
      sel_idx     = req_idx[int'(gidx)*IDX_W +: IDX_W];
      sel_operand = req_operand[int'(gidx)*DATA_W +: DATA_W];
      sel_addr    = {sel_bank, sel_idx};
      old_val     = words[sel_addr];
      is_irq      = (sel_op == OP_IRQ_ONE) || (sel_op == OP_IRQ_MASK);
      refused     = sel_bank && !sel_priv && !is_irq;
      commit      = any_gnt && alu_wr && !refused && !is_irq;
   end

   acrf_atomic_alu #(.W(DATA_W)) u_alu (
      .op(sel_op), .old_val(old_val), .operand(sel_operand),
      .new_val(new_val), .do_write(alu_wr)
   );

   acrf_irq_fanout #(.NCPU(NUM_CPUS), .W(DATA_W)) u_irq (
      .clk(clk), .rst_n(rst_n), .fire(any_gnt), .op(sel_op),
      .operand(sel_operand), .irq(irq_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int a = 0; a < DEPTH; a++) words[a] <= '0;
      end else if (commit) begin
         words[sel_addr] <= new_val;
      end
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rsp
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rsp_valid[p]                 <= 1'b0;
            rsp_err[p]                   <= 1'b0;
            rsp_data[p*DATA_W +: DATA_W] <= '0;
         end else begin
            rsp_valid[p] <= req_ready[p];
            rsp_err[p]   <= req_ready[p] && refused;
            if (req_ready[p])
               rsp_data[p*DATA_W +: DATA_W] <= (refused || is_irq) ? '0 : old_val;
         end
      end
   end
endmodule

// File: rtl/acrf_checker.sv
`timescale 1ns/1ps
module acrf_checker #(
   parameter int NUM_PORTS = 4,
   parameter int DATA_W    = 64,
   parameter int NUM_CPUS  = 8
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [NUM_PORTS-1:0]         req_valid,
   input logic [NUM_PORTS-1:0]         req_ready,
   input logic [NUM_PORTS-1:0]         rsp_valid,
   input logic [NUM_PORTS-1:0]         rsp_err,
   input logic [NUM_PORTS*DATA_W-1:0]  rsp_data,
   input logic [NUM_CPUS-1:0]          irq_out
);
   a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_ready));

   a_r2_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready & ~req_valid) == '0);

   a_r3_rsp_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_ready) |=> $countones(rsp_valid) == 1);

   a_r3_no_rsp_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
      !(|req_ready) |=> rsp_valid == '0);

   a_r9_irq_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_out) |-> $past(|req_ready));

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      a_r8_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_err[p] |-> (rsp_valid[p] && rsp_data[p*DATA_W +: DATA_W] == '0));
   end
endmodule

bind acrf_sync_regfile acrf_checker #(
   .NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W), .NUM_CPUS(NUM_CPUS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data), .irq_out(irq_out)
);

// File: tb/tb_acrf_sync_regfile.sv
`timescale 1ns/1ps
module tb_acrf_sync_regfile;
   localparam int P = 4, NR = 128, W = 64, NC = 8, IW = 7;
   localparam int NINC = 25;

   logic clk = 0, rst_n = 0;
   always #5 clk = ~clk;

   logic [P-1:0]      req_valid, req_ready, req_bank, req_priv, rsp_valid, rsp_err;
   logic [P*3-1:0]    req_op;
   logic [P*IW-1:0]   req_idx;
   logic [P*W-1:0]    req_operand, rsp_data;
   logic [NC-1:0]     irq_out;

   logic         b_valid [P];
   logic [2:0]   b_op    [P];
   logic         b_bank  [P];
   logic         b_priv  [P];
   logic [IW-1:0] b_idx  [P];
   logic [W-1:0] b_opnd  [P];

   always_comb begin
      for (int p = 0; p < P; p++) begin
         req_valid[p]              = b_valid[p];
         req_op[p*3 +: 3]          = b_op[p];
         req_bank[p]               = b_bank[p];
         req_priv[p]               = b_priv[p];
         req_idx[p*IW +: IW]       = b_idx[p];
         req_operand[p*W +: W]     = b_opnd[p];
      end
   end

   acrf_sync_regfile #(.NUM_PORTS(P), .NUM_REGS(NR), .DATA_W(W), .NUM_CPUS(NC)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_bank(req_bank), .req_priv(req_priv), .req_idx(req_idx),
      .req_operand(req_operand), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
      .rsp_data(rsp_data), .irq_out(irq_out)
   );

   int checks = 0, failures = 0, cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_req(input int p, input logic [2:0] op, input logic bank, input logic priv,
                         input int idx, input logic [W-1:0] opnd,
                         output logic [W-1:0] data, output logic err,
                         output logic [NC-1:0] irq, output int done);
      @(negedge clk);
      b_op[p] = op; b_bank[p] = bank; b_priv[p] = priv;
      b_idx[p] = IW'(idx); b_opnd[p] = opnd; b_valid[p] = 1'b1;
      #1;
      while (!req_ready[p]) begin @(negedge clk); #1; end
      @(negedge clk);
      b_valid[p] = 1'b0;
      data = rsp_data[p*W +: W];
      err  = rsp_err[p];
      irq  = irq_out;
      done = cyc;
      if (!rsp_valid[p]) check(0, "R3 rsp_valid missing", 0, 1);
   endtask

   logic [W-1:0] d; logic e; logic [NC-1:0] q; int dc;

   task automatic t_reset();
      check(rsp_valid == 0, "R1 rsp_valid", W'(rsp_valid), 0);
      check(irq_out == 0 && rsp_err == 0, "R1 irq/err", W'(irq_out), 0);
      check(req_ready == 0, "R1 req_ready", W'(req_ready), 0);
      do_req(0, 3'd0, 1'b0, 1'b0, 5, 0, d, e, q, dc);
      check(d == 0, "R1 user word zero", d, 0);
      do_req(1, 3'd0, 1'b1, 1'b1, 127, 0, d, e, q, dc);
      check(d == 0 && !e, "R1 supervisor word zero", d, 0);
   endtask

   task automatic t_tas();
      do_req(0, 3'd1, 0, 0, 3, 0, d, e, q, dc);
      check(d == 0, "R4 first tas old", d, 0);
      do_req(1, 3'd1, 0, 0, 3, 0, d, e, q, dc);
      check(d == 64'h8000_0000_0000_0000, "R4 second tas old", d, 64'h8000_0000_0000_0000);
      do_req(2, 3'd5, 0, 0, 3, 64'h5, d, e, q, dc);
      do_req(3, 3'd1, 0, 0, 3, 0, d, e, q, dc);
      check(d == 64'h8000_0000_0000_0005, "R4 tas keeps low bits", d, 64'h8000_0000_0000_0005);
   endtask

   task automatic t_logic();
      do_req(0, 3'd5, 0, 0, 10, 64'hF0F0, d, e, q, dc);
      do_req(1, 3'd2, 0, 0, 10, 64'hFF00, d, e, q, dc);
      check(d == 64'hF0F0, "R5 and old", d, 64'hF0F0);
      do_req(2, 3'd3, 0, 0, 10, 64'h000F, d, e, q, dc);
      check(d == 64'hF000, "R5 or old", d, 64'hF000);
      do_req(3, 3'd0, 0, 0, 10, 0, d, e, q, dc);
      check(d == 64'hF00F, "R5 final", d, 64'hF00F);
   endtask

   task automatic t_wrap();
      do_req(0, 3'd5, 0, 0, 20, '1, d, e, q, dc);
      do_req(1, 3'd4, 0, 0, 20, 0, d, e, q, dc);
      check(d == '1, "R6 finc old all-ones", d, '1);
      do_req(2, 3'd5, 0, 0, 20, 64'd7, d, e, q, dc);
      check(d == 0, "R6 finc wrapped", d, 0);
      do_req(3, 3'd5, 0, 0, 20, 64'hFFFF_FFFF_FFFF_FFFE, d, e, q, dc);
      do_req(0, 3'd0, 0, 0, 20, 0, d, e, q, dc);
      check(d == 64'd5, "R6 add wrapped", d, 64'd5);
   endtask

   task automatic t_load();
      do_req(1, 3'd0, 0, 0, 20, 64'h1234, d, e, q, dc);
      do_req(2, 3'd0, 0, 0, 20, 0, d, e, q, dc);
      check(d == 64'd5, "R7 load unchanged", d, 64'd5);
   endtask

   task automatic t_priv();
      do_req(0, 3'd5, 1, 0, 4, 64'd7, d, e, q, dc);
      check(e == 1 && d == 0, "R8 refused flag", {63'd0, e}, 1);
      do_req(1, 3'd0, 1, 1, 4, 0, d, e, q, dc);
      check(d == 0 && !e, "R8 refused left word", d, 0);
      do_req(2, 3'd5, 1, 1, 4, 64'd9, d, e, q, dc);
      check(d == 0 && !e, "R8 priv add old", d, 0);
      do_req(3, 3'd0, 1, 0, 4, 0, d, e, q, dc);
      check(e == 1 && d == 0, "R8 unpriv load refused", d, 0);
      do_req(0, 3'd0, 1, 1, 4, 0, d, e, q, dc);
      check(d == 64'd9, "R8 priv word", d, 64'd9);
      do_req(1, 3'd0, 0, 0, 4, 0, d, e, q, dc);
      check(d == 0, "R8 user bank independent", d, 0);
   endtask

   task automatic t_irq();
      do_req(2, 3'd6, 0, 0, 0, 64'd5, d, e, q, dc);
      check(q == 8'b0010_0000, "R9 single target", W'(q), 64'h20);
      check(d == 0, "R9 rsp data zero", d, 0);
      @(negedge clk);
      check(irq_out == 0, "R9 pulse ends", W'(irq_out), 0);
      do_req(3, 3'd6, 0, 0, 0, 64'd8, d, e, q, dc);
      check(q == 0, "R9 out-of-range target", W'(q), 0);
      do_req(0, 3'd7, 0, 0, 0, 64'hA5, d, e, q, dc);
      check(q == 8'hA5, "R10 mask", W'(q), 64'hA5);
      @(negedge clk);
      check(irq_out == 0, "R10 pulse ends", W'(irq_out), 0);
      do_req(1, 3'd7, 0, 0, 0, 64'h1_03, d, e, q, dc);
      check(q == 8'h03, "R10 high bits ignored", W'(q), 64'h03);
   endtask

   task automatic t_arb();
      int dn [P];
      for (int p = 0; p < P; p++) begin
         automatic int pp = p;
         fork
            begin
               logic [W-1:0] ld; logic le; logic [NC-1:0] lq; int ldc;
               do_req(pp, 3'd0, 0, 0, 1, 0, ld, le, lq, ldc);
               dn[pp] = ldc;
            end
         join_none
      end
      wait fork;
      begin
         int mn, mx; bit dup;
         mn = dn[0]; mx = dn[0]; dup = 0;
         for (int i = 0; i < P; i++) begin
            if (dn[i] < mn) mn = dn[i];
            if (dn[i] > mx) mx = dn[i];
            for (int j = i + 1; j < P; j++) if (dn[i] == dn[j]) dup = 1;
         end
         check(!dup, "R2 one grant per cycle", W'(dup), 0);
         check(mx - mn == P - 1, "R2 round-robin spread", W'(mx - mn), W'(P - 1));
      end
   endtask

   task automatic t_conc();
      bit seen [P*NINC];
      int bad = 0;
      for (int i = 0; i < P*NINC; i++) seen[i] = 0;
      for (int p = 0; p < P; p++) begin
         automatic int pp = p;
         fork
            for (int n = 0; n < NINC; n++) begin
               logic [W-1:0] ld; logic le; logic [NC-1:0] lq; int ldc;
               repeat ($urandom_range(0, 2)) @(negedge clk);
               do_req(pp, 3'd4, 0, 0, 50, 0, ld, le, lq, ldc);
               if (ld >= W'(P*NINC) || seen[int'(ld)]) bad++;
               else seen[int'(ld)] = 1;
            end
         join_none
      end
      wait fork;
      check(bad == 0, "R11 unique old values", W'(bad), 0);
      do_req(0, 3'd0, 0, 0, 50, 0, d, e, q, dc);
      check(d == W'(P*NINC), "R11 final count", d, W'(P*NINC));
   endtask

   initial begin
      for (int p = 0; p < P; p++) begin
         b_valid[p] = 0; b_op[p] = 0; b_bank[p] = 0; b_priv[p] = 0; b_idx[p] = 0; b_opnd[p] = 0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;
      @(negedge clk);
      t_reset();
      t_tas();
      t_logic();
      t_wrap();
      t_load();
      t_priv();
      t_irq();
      t_arb();
      t_conc();
      repeat (2) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #200_000ns;
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule